// File: doc/BRIEF.md
# Serial Word Shifter with Odd Parity

This block sits between a word-wide transfer engine and a bit-serial storage channel. In write direction it takes 16-bit words from the engine and turns each into a 17-bit serial frame. The frame carries the 16 data bits, least significant first, and then one parity bit chosen so that the frame holds an odd number of ones. In read direction it collects 17-bit frames from the serial input and presents the 16 data bits as a parallel word. It also checks parity and keeps a sticky error flag.

Serial timing comes from a single-cycle bit pulse supplied by the channel. An internal slot counter frames the words. It counts data pulses, wraps after the sixteenth, and spends the next pulse on the parity slot. Each word therefore starts with the counter at zero. A service-request flag asks the engine for the next write word or tells it a read word is ready. The engine clears the flag with an acknowledge. If the engine has not supplied a new write word by the time a frame starts, the held word is sent again. This is how a short final block gets padded out.

Top module: `sws_shifter`

## Requirements
- R1: After reset, `ser_out`, `svc_req`, `par_err` and `rd_word` are all zero.
- R2: In write direction with `run` high, each frame spans 17 `bit_tick` pulses. After the k-th data pulse of a frame (k = 0..15), `ser_out` shows bit k of the word. After the 17th pulse it shows the parity bit. `ser_out` changes only on a `bit_tick` cycle.
- R3: The parity bit sent in write direction makes the number of ones across the 17 bits odd. That is, it equals the inverted XOR of the 16 data bits.
- R4: In write direction, a `start` pulse with `run` high sets `svc_req` on the next cycle. The first pulse of every frame also sets it on the next cycle. An acknowledge in a cycle with no `bit_tick` and no `start` clears it on the next cycle.
- R5: A word is taken from `wr_word` when `svc_ack` is high while `svc_req` is high. If no word is taken between two frame starts, the later frame repeats the previous word.
- R6: In read direction, the first serial bit of a frame lands in bit 0 of `rd_word`. `rd_word` and `svc_req` update on the 17th pulse of the frame and at no other time.
- R7: In read direction, `par_err` is set on the 17th pulse if the frame holds an even number of ones. It stays set through later good frames until the next `start`.
- R8: `start` resets the slot counter, so the next pulse begins a new frame. It also clears `par_err` and the read parity state, and clears `svc_req` in read direction.
- R9: With `run` low, `bit_tick` pulses are ignored, `ser_out` is zero, and `svc_req` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run | input | 1 | Transfer enable |
| start | input | 1 | Single-cycle transfer start |
| dir_wr | input | 1 | 1 = write (parallel to serial), 0 = read |
| bit_tick | input | 1 | Single-cycle serial bit pulse |
| ser_in | input | 1 | Serial data from the channel |
| ser_out | output | 1 | Serial data to the channel |
| wr_word | input | 16 | Parallel word from the engine |
| rd_word | output | 16 | Parallel word to the engine |
| svc_req | output | 1 | Service request toward the engine |
| svc_ack | input | 1 | Acknowledge from the engine |
| par_err | output | 1 | Sticky read parity error |

## Verification
Write frames are driven with random words and with all-zero and all-one words. These tell bit order and parity polarity apart, since the all-zero word needs a parity one and the all-one word needs a parity one as well over an even count. Random gaps in the acknowledge sequence show whether an unserved frame repeats its word or sends stale shifter contents. Read frames mix good and deliberately corrupted parity, which separates a sticky flag from one that follows the latest frame. A restart issued partway through a frame shows whether framing realigns to the next pulse.

// File: rtl/sws_pkg.sv
package sws_pkg;
  localparam int unsigned SWS_WORD_W = 16;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } sws_dir_e;
endpackage

// File: rtl/sws_bitcnt.sv
// Frame slot counter: counts data pulses, wraps after the last one and
// spends the following pulse on the parity slot.
module sws_bitcnt #(
  parameter int unsigned WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic start,
  input  logic bit_tick,
  output logic word_first,
  output logic data_tick,
  output logic par_tick
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             slot_q, slot_d;
  logic             tick_en;
  logic             near_end;

  assign tick_en    = run && bit_tick && !start;
  assign near_end   = (cnt_q == CNT_LAST);
  assign word_first = tick_en && !slot_q && (cnt_q == '0);
  assign data_tick  = tick_en && !slot_q;
  assign par_tick   = tick_en && slot_q;

  always_comb begin
    cnt_d  = cnt_q;
    slot_d = slot_q;
    if (start) begin
      cnt_d  = '0;
      slot_d = 1'b0;
    end else if (tick_en) begin
      if (slot_q) begin
        slot_d = 1'b0;            // blocked pulse: count stays at zero
      end else if (near_end) begin
        cnt_d  = '0;
        slot_d = 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/sws_wr_path.sv
// Parallel-to-serial path with odd parity generation.
module sws_wr_path #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              take,
  input  logic              word_first,
  input  logic              data_tick,
  input  logic              par_tick,
  input  logic [WORD_W-1:0] wr_word,
  output logic              ser_out
);
  logic [WORD_W-1:0] hold_q, hold_d;
  logic [WORD_W-1:0] shf_q, shf_d;
  logic [WORD_W-1:0] src;
  logic              par_q, par_d;
  logic              ser_q, ser_d;

  assign src     = take ? wr_word : hold_q;
  assign ser_out = ser_q;

  always_comb begin
    hold_d = take ? wr_word : hold_q;
    shf_d  = shf_q;
    par_d  = par_q;
    ser_d  = ser_q;
    if (!en) begin
      ser_d = 1'b0;
    end else if (word_first) begin
      shf_d = src;
      ser_d = src[0];
      par_d = 1'b1 ^ src[0];
    end else if (data_tick) begin
      shf_d = {1'b0, shf_q[WORD_W-1:1]};
      ser_d = shf_q[1];
      par_d = par_q ^ shf_q[1];
    end else if (par_tick) begin
      ser_d = par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      shf_q  <= '0;
      par_q  <= 1'b1;
      ser_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      shf_q  <= shf_d;
      par_q  <= par_d;
      ser_q  <= ser_d;
    end
  end
endmodule

// File: rtl/sws_rd_path.sv
// Serial-to-parallel path with parity check (toggle on each zero).
module sws_rd_path #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              data_tick,
  input  logic              par_tick,
  input  logic              ser_in,
  output logic [WORD_W-1:0] rd_word,
  output logic              par_err,
  output logic              word_done
);
  logic [WORD_W-1:0] shf_q, shf_d;
  logic [WORD_W-1:0] out_q, out_d;
  logic              zpar_q, zpar_d;
  logic              err_q, err_d;
  logic              bad_frame;

  assign bad_frame = zpar_q ^ ~ser_in;
  assign word_done = en && par_tick;
  assign rd_word   = out_q;
  assign par_err   = err_q;

  always_comb begin
    shf_d  = shf_q;
    out_d  = out_q;
    zpar_d = zpar_q;
    err_d  = err_q;
    if (start) begin
      zpar_d = 1'b0;
      err_d  = 1'b0;
    end else if (en && data_tick) begin
      shf_d  = {ser_in, shf_q[WORD_W-1:1]};
      zpar_d = zpar_q ^ ~ser_in;
    end else if (en && par_tick) begin
      out_d  = shf_q;
      zpar_d = 1'b0;
      if (bad_frame) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q  <= '0;
      out_q  <= '0;
      zpar_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      shf_q  <= shf_d;
      out_q  <= out_d;
      zpar_q <= zpar_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/sws_shifter.sv
module sws_shifter
  import sws_pkg::*;
#(
  parameter int unsigned WORD_W = SWS_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic              dir_wr,
  input  logic              bit_tick,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word,
  output logic              svc_req,
  input  logic              svc_ack,
  output logic              par_err
);
  sws_dir_e dir;
  logic     en_wr, en_rd;
  logic     word_first, data_tick, par_tick;
  logic     rd_done;
  logic     take;
  logic     req_set;
  logic     req_q, req_d;

  assign dir   = sws_dir_e'(dir_wr);
  assign en_wr = run && (dir == DIR_WR);
  assign en_rd = run && (dir == DIR_RD);
  assign take  = req_q && svc_ack && (dir == DIR_WR);

  sws_bitcnt #(.WORD_W(WORD_W)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .start      (start),
    .bit_tick   (bit_tick),
    .word_first (word_first),
    .data_tick  (data_tick),
    .par_tick   (par_tick)
  );

  sws_wr_path #(.WORD_W(WORD_W)) i_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_wr),
    .take       (take),
    .word_first (word_first),
    .data_tick  (data_tick),
    .par_tick   (par_tick),
    .wr_word    (wr_word),
    .ser_out    (ser_out)
  );

  sws_rd_path #(.WORD_W(WORD_W)) i_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_rd),
    .start      (start),
    .data_tick  (data_tick),
    .par_tick   (par_tick),
    .ser_in     (ser_in),
    .rd_word    (rd_word),
    .par_err    (par_err),
    .word_done  (rd_done)
  );

  assign req_set = (en_wr && (start || word_first)) || rd_done;

  always_comb begin
    req_d = req_q;
    if (req_set)              req_d = 1'b1;
    else if (start)           req_d = 1'b0;
    else if (svc_ack)         req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign svc_req = req_q;
endmodule

// File: rtl/sws_checker.sv
module sws_checker #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              start,
  input logic              dir_wr,
  input logic              bit_tick,
  input logic              ser_out,
  input logic [WORD_W-1:0] rd_word,
  input logic              svc_req,
  input logic              svc_ack,
  input logic              par_err
);
  AST_SER_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bit_tick) |=> $stable(ser_out)); // R2
  AST_RD_DIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !dir_wr) |=> !ser_out); // R2
  AST_REQ_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && run && dir_wr) |=> svc_req); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && svc_ack && !bit_tick && !start) |=> !svc_req); // R4
  AST_RD_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && !dir_wr && bit_tick) |=> $stable(rd_word)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !start) |=> par_err); // R7
  AST_START_CLR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !par_err); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !ser_out); // R9
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !svc_req) |=> !svc_req); // R9
endmodule

bind sws_shifter sws_checker #(.WORD_W(WORD_W)) i_sws_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .start    (start),
  .dir_wr   (dir_wr),
  .bit_tick (bit_tick),
  .ser_out  (ser_out),
  .rd_word  (rd_word),
  .svc_req  (svc_req),
  .svc_ack  (svc_ack),
  .par_err  (par_err)
);

// File: tb/test_sws_shifter.sv
`timescale 1ns/1ps
module test_sws_shifter;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n, run, start, dir_wr, bit_tick, ser_in, svc_ack;
  logic         ser_out, svc_req, par_err;
  logic [W-1:0] wr_word, rd_word;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sws_shifter i_sws_shifter (
    .clk(clk), .rst_n(rst_n), .run(run), .start(start), .dir_wr(dir_wr),
    .bit_tick(bit_tick), .ser_in(ser_in), .ser_out(ser_out),
    .wr_word(wr_word), .rd_word(rd_word), .svc_req(svc_req),
    .svc_ack(svc_ack), .par_err(par_err)
  );

  function automatic logic odd_par(input logic [W-1:0] w);
    return ~^w;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic din);
    @(negedge clk); ser_in = din; bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic ack(input logic [W-1:0] w);
    @(negedge clk); wr_word = w; svc_ack = 1'b1;
    @(negedge clk); svc_ack = 1'b0;
  endtask

  task automatic send_frame(input logic [W-1:0] w, input logic bad);
    for (int k = 0; k < W; k++) tick(w[k]);
    tick(odd_par(w) ^ bad);
  endtask

  initial begin
    #700000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] cur, w;
    logic         exp_err;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; run = 1'b0; start = 1'b0; dir_wr = 1'b1; bit_tick = 1'b0;
    ser_in = 1'b0; svc_ack = 1'b0; wr_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ser_out", W'(ser_out), '0);
    chk("R1 svc_req", W'(svc_req), '0);
    chk("R1 par_err", W'(par_err), '0);
    chk("R1 rd_word", rd_word, '0);

    // ---------------- write direction ----------------
    dir_wr = 1'b1; run = 1'b1;
    pulse_start();
    chk("R4 req after start", W'(svc_req), 1);
    cur = '0;
    for (int n = 0; n < 30; n++) begin
      bit give = (n < 3) || ($urandom_range(3) != 0);
      if (give) begin
        w = (n == 1) ? '0 : (n == 2) ? '1 : W'($urandom);
        ack(w);
        chk("R4 ack clears req", W'(svc_req), 0);
        cur = w;
      end
      // cur is the expected word: new one, or repeated one (R5)
      for (int k = 0; k < W; k++) begin
        tick(1'b0);
        if (k == 0) chk("R4 req at frame start", W'(svc_req), 1);
        chk(give ? "R2 data bit" : "R5 repeated bit", W'(ser_out), W'(cur[k]));
      end
      tick(1'b0);
      chk("R3 parity bit", W'(ser_out), W'(odd_par(cur)));
    end

    // R9 ignored pulses while idle
    run = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      tick(1'b1);
      chk("R9 idle ser_out", W'(ser_out), 0);
    end
    ack(16'h1357);
    chk("R9 req cleared idle", W'(svc_req), 0);
    tick(1'b0);
    chk("R9 no req while idle", W'(svc_req), 0);

    // ---------------- read direction ----------------
    dir_wr = 1'b0; run = 1'b1;
    pulse_start();
    chk("R8 start clears req rd", W'(svc_req), 0);
    exp_err = 1'b0;
    for (int n = 0; n < 24; n++) begin
      logic bad;
      w   = (n == 0) ? '0 : (n == 1) ? '1 : W'($urandom);
      bad = (n == 6) || (n > 8 && $urandom_range(7) == 0);
      for (int k = 0; k < W; k++) tick(w[k]);
      chk("R6 no req before parity slot", W'(svc_req), 0);
      tick(odd_par(w) ^ bad);
      exp_err = exp_err | bad;
      chk("R6 rd_word", rd_word, w);
      chk("R6 req on word", W'(svc_req), 1);
      chk("R7 par_err", W'(par_err), W'(exp_err));
      ack('0);
      chk("R4 ack clears rd req", W'(svc_req), 0);
    end

    // R8 restart mid-frame realigns framing and clears the error
    for (int k = 0; k < 5; k++) tick(1'b1);
    pulse_start();
    chk("R8 start clears par_err", W'(par_err), 0);
    w = 16'hA5C3;
    send_frame(w, 1'b0);
    chk("R8 realigned rd_word", rd_word, w);
    chk("R8 no error after restart", W'(par_err), 0);
    ack('0);

    // R8 in write direction: restart after a partial frame
    dir_wr = 1'b1;
    pulse_start();
    ack(16'h0F0F);
    for (int k = 0; k < 7; k++) tick(1'b0);
    pulse_start();
    ack(16'h8001);
    for (int k = 0; k < W; k++) begin
      tick(1'b0);
      chk("R8 write realigned bit", W'(ser_out), W'(k == 0 || k == 15));
    end
    tick(1'b0);
    chk("R8 write realigned parity", W'(ser_out), W'(odd_par(16'h8001)));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule